// File: doc/BRIEF.md
# Configuration Image Download Sequencer

This block brings up an SRAM-based programmable device by loading its configuration image over the device's 8-bit parallel slave port. Image bytes come in on a valid/ready byte stream that stands in for the flash reader. The block drives the device's active-low program strobe, its configuration clock and its data bus. It also watches the device's init and done status lines.

The `start_i` input runs a fixed bring-up sequence. First the program strobe goes low for a set number of cycles, which clears the device. The block then waits for init to be released, with a timeout on that wait. Only after that does the configuration clock start, and the bytes are streamed one per clock. After the last byte a few extra clocks are given, and then the done line is sampled. The same start is issued on a cold start and again after every resume from low power, because the device loses its configuration when powered down. A not-ready output holds off dependent logic until a download has succeeded. Outcomes are reported as busy, success and error, and a two-bit code gives the cause of an error.

Top module: `cfg_loader`

## Requirements
- R1: After reset the strobe is high, the configuration clock is low, busy, success and error are low, the not-ready output is high, the byte input is not ready and the error cause is 0.
- R2: A start while not busy drives the program strobe low for exactly PROG_LOW_CYCLES clocks. A start while busy is ignored, so the strobe falls only once per download.
- R3: No configuration clock edge and no byte acceptance happen before init is seen high after the strobe pulse.
- R4: Each accepted byte appears on the data bus and is held stable while the configuration clock is high. The device therefore captures the bytes in stream order, one per rising edge.
- R5: The configuration clock period is CCLK_DIV system clocks while bytes arrive back to back. The clock stays low whenever no byte is pending.
- R6: If init stays low for INIT_WAIT_MAX clocks after the strobe is released, the block enters error with cause 2'b01. The strobe stays high and the clock stays low.
- R7: After the last byte (marked by `img_last_i`) the block gives TAIL_CCLKS more configuration clocks and then samples done. If done is high, success is raised.
- R8: If done is low at that sample, the block enters error with cause 2'b11.
- R9: If init goes low while bytes or tail clocks are being sent, the block enters error with cause 2'b10 and the configuration clock stops.
- R10: Success and error are never high together. Not-ready is high except in success. A new start from success or from error repeats the full sequence.
- R11: The byte input is ready only while streaming is in progress with init high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a download (cold start or resume) |
| img_valid_i | input | 1 | Image byte valid |
| img_data_i | input | 8 | Image byte |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Image byte accepted when high with valid |
| cfg_prog_n_o | output | 1 | Active-low program strobe to the device |
| cfg_cclk_o | output | 1 | Configuration clock to the device |
| cfg_data_o | output | 8 | Configuration data bus |
| cfg_init_i | input | 1 | Device init status (high when ready for data) |
| cfg_done_i | input | 1 | Device done status |
| busy_o | output | 1 | Download in progress |
| ok_o | output | 1 | Last download succeeded |
| err_o | output | 1 | Last download failed |
| err_cause_o | output | 2 | 01 init timeout, 10 init lost, 11 done missing |
| dev_not_ready_o | output | 1 | Holds off logic that needs a configured device |

## Verification
The bench builds the block with a 5-cycle strobe pulse, a clock divider of 4, an init timeout of 40 cycles and 3 tail clocks. These short values let the timeout error be reached in tens of cycles and keep the tail clock count easy to check. With them, many complete downloads fit in one short run, including restarts after an error. The divider of 4 gives two-cycle clock phases, so the rising-edge spacing and the data hold can be measured exactly. A device model in the bench raises init after a random delay, can drop it mid-stream, and drives done from a per-case setting.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
// Shared types for the configuration download sequencer.
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PROG,
        SEQ_WAIT_INIT,
        SEQ_STREAM,
        SEQ_TAIL,
        SEQ_OK,
        SEQ_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_INIT_TO  = 2'b01,
        CAUSE_INIT_LOST = 2'b10,
        CAUSE_NO_DONE  = 2'b11
    } err_cause_t;

endpackage

// File: rtl/cfg_span_timer.sv
`timescale 1ns/1ps
// Cycle/event counter used for the strobe pulse, the init timeout and the
// tail clock count. It clears on clr_i and counts enabled events until it
// reaches limit_i, where it holds. Assumes limit_i is stable while counting.
module cfg_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;

    assign hit_o = (cnt_q == limit_i);

    // Count enabled events up to the limit; clear when a new phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !hit_o) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/cfg_cclk_gen.sv
`timescale 1ns/1ps
// Configuration clock and data driver. In stream mode it accepts one byte
// per clock period, puts it on the bus while the clock is low and raises the
// clock halfway through the period. The clock stays low when no byte is
// pending. In tail mode it runs free with no data. Assumes DIV is even, >= 2.
module cfg_cclk_gen #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       stream_i,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    input  logic       last_i,
    output logic       ready_o,
    output logic       cclk_o,
    output logic [7:0] data_o,
    output logic       last_done_o,
    output logic       beat_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic          have_q;
    logic          last_q;
    logic          cclk_q;
    logic [CW-1:0] ph_q;
    logic [7:0]    data_q;
    logic          wrap;
    logic          active;
    logic          take;

    assign wrap        = (ph_q == CW'(DIV - 1));
    assign active      = have_q || (run_i && !stream_i);
    assign ready_o     = run_i && stream_i && !last_q && (!have_q || wrap);
    assign take        = ready_o && valid_i;
    assign cclk_o      = cclk_q;
    assign data_o      = data_q;
    assign last_done_o = stream_i && have_q && last_q && wrap;
    assign beat_o      = run_i && !stream_i && wrap;

    // Advance the clock phase, load bytes at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
            cclk_q <= 1'b0;
            ph_q   <= '0;
            data_q <= '0;
        end else if (!run_i) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
            cclk_q <= 1'b0;
            ph_q   <= '0;
        end else if (active) begin
            if (wrap) begin
                cclk_q <= 1'b0;
                ph_q   <= '0;
                have_q <= take;
                if (take) begin
                    data_q <= data_i;
                    last_q <= last_i;
                end
            end else begin
                ph_q <= ph_q + CW'(1);
                if (ph_q == CW'(HALF - 1)) begin
                    cclk_q <= 1'b1;
                end
            end
        end else if (take) begin
            have_q <= 1'b1;
            data_q <= data_i;
            last_q <= last_i;
            ph_q   <= '0;
        end
    end
endmodule

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
// Bring-up sequencer: strobe pulse, init wait with timeout, streaming, tail
// clocks and the done check. The cfg_span_timer measures each phase. Assumes
// the device holds init low while it clears and raises it when ready.
module cfg_seq
    import cfg_loader_pkg::*;
#(
    parameter int PROG_LOW_CYCLES = 16,
    parameter int INIT_WAIT_MAX   = 4096,
    parameter int TAIL_CCLKS      = 8,
    parameter int TW              = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         init_i,
    input  logic         done_i,
    input  logic         last_done_i,
    input  logic         beat_i,
    input  logic         hit_i,
    output logic         tmr_clr_o,
    output logic         tmr_en_o,
    output logic [TW-1:0] tmr_limit_o,
    output logic         run_o,
    output logic         stream_o,
    output seq_state_t   state_o,
    output err_cause_t   cause_o
);
    seq_state_t state_q, state_d;
    err_cause_t cause_q, cause_d;

    // Pick the next phase from the current phase and the device status.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            SEQ_IDLE, SEQ_OK, SEQ_ERR: begin
                if (start_i) begin
                    state_d = SEQ_PROG;
                    cause_d = CAUSE_NONE;
                end
            end
            SEQ_PROG: begin
                if (hit_i) state_d = SEQ_WAIT_INIT;
            end
            SEQ_WAIT_INIT: begin
                if (init_i) begin
                    state_d = SEQ_STREAM;
                end else if (hit_i) begin
                    state_d = SEQ_ERR;
                    cause_d = CAUSE_INIT_TO;
                end
            end
            SEQ_STREAM: begin
                if (!init_i) begin
                    state_d = SEQ_ERR;
                    cause_d = CAUSE_INIT_LOST;
                end else if (last_done_i) begin
                    state_d = SEQ_TAIL;
                end
            end
            SEQ_TAIL: begin
                if (!init_i) begin
                    state_d = SEQ_ERR;
                    cause_d = CAUSE_INIT_LOST;
                end else if (beat_i && hit_i) begin
                    state_d = done_i ? SEQ_OK : SEQ_ERR;
                    cause_d = done_i ? CAUSE_NONE : CAUSE_NO_DONE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Hold the phase and the recorded error cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Timer control: restart on each phase change, choose what it measures.
    always_comb begin
        tmr_clr_o   = (state_d != state_q);
        tmr_en_o    = 1'b0;
        tmr_limit_o = '0;
        case (state_q)
            SEQ_PROG: begin
                tmr_en_o    = 1'b1;
                tmr_limit_o = TW'(PROG_LOW_CYCLES - 1);
            end
            SEQ_WAIT_INIT: begin
                tmr_en_o    = 1'b1;
                tmr_limit_o = TW'(INIT_WAIT_MAX - 1);
            end
            SEQ_TAIL: begin
                tmr_en_o    = beat_i;
                tmr_limit_o = TW'(TAIL_CCLKS - 1);
            end
            default: ;
        endcase
    end

    assign stream_o = (state_q == SEQ_STREAM);
    assign run_o    = ((state_q == SEQ_STREAM) || (state_q == SEQ_TAIL)) && init_i;
    assign state_o  = state_q;
    assign cause_o  = cause_q;
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
// Top of the configuration download sequencer. It joins the phase sequencer,
// the phase timer and the configuration clock/data driver. Assumes the image
// stream marks its final byte with img_last_i.
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int PROG_LOW_CYCLES = 16,
    parameter int CCLK_DIV        = 4,
    parameter int INIT_WAIT_MAX   = 4096,
    parameter int TAIL_CCLKS      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       img_valid_i,
    input  logic [7:0] img_data_i,
    input  logic       img_last_i,
    output logic       img_ready_o,
    output logic       cfg_prog_n_o,
    output logic       cfg_cclk_o,
    output logic [7:0] cfg_data_o,
    input  logic       cfg_init_i,
    input  logic       cfg_done_i,
    output logic       busy_o,
    output logic       ok_o,
    output logic       err_o,
    output logic [1:0] err_cause_o,
    output logic       dev_not_ready_o
);
    localparam int MAX_AB = (PROG_LOW_CYCLES > INIT_WAIT_MAX) ? PROG_LOW_CYCLES : INIT_WAIT_MAX;
    localparam int MAX_L  = (MAX_AB > TAIL_CCLKS) ? MAX_AB : TAIL_CCLKS;
    localparam int TW     = $clog2(MAX_L + 1);

    logic          tmr_clr;
    logic          tmr_en;
    logic [TW-1:0] tmr_limit;
    logic          tmr_hit;
    logic          run;
    logic          stream;
    logic          last_done;
    logic          beat;
    seq_state_t    state;
    err_cause_t    cause;

    cfg_seq #(
        .PROG_LOW_CYCLES (PROG_LOW_CYCLES),
        .INIT_WAIT_MAX   (INIT_WAIT_MAX),
        .TAIL_CCLKS      (TAIL_CCLKS),
        .TW              (TW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .init_i      (cfg_init_i),
        .done_i      (cfg_done_i),
        .last_done_i (last_done),
        .beat_i      (beat),
        .hit_i       (tmr_hit),
        .tmr_clr_o   (tmr_clr),
        .tmr_en_o    (tmr_en),
        .tmr_limit_o (tmr_limit),
        .run_o       (run),
        .stream_o    (stream),
        .state_o     (state),
        .cause_o     (cause)
    );

    cfg_span_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .en_i    (tmr_en),
        .limit_i (tmr_limit),
        .hit_o   (tmr_hit)
    );

    cfg_cclk_gen #(.DIV(CCLK_DIV)) u_cclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .stream_i    (stream),
        .valid_i     (img_valid_i),
        .data_i      (img_data_i),
        .last_i      (img_last_i),
        .ready_o     (img_ready_o),
        .cclk_o      (cfg_cclk_o),
        .data_o      (cfg_data_o),
        .last_done_o (last_done),
        .beat_o      (beat)
    );

    assign cfg_prog_n_o    = (state != SEQ_PROG);
    assign busy_o          = (state == SEQ_PROG) || (state == SEQ_WAIT_INIT) ||
                             (state == SEQ_STREAM) || (state == SEQ_TAIL);
    assign ok_o            = (state == SEQ_OK);
    assign err_o           = (state == SEQ_ERR);
    assign err_cause_o     = cause;
    assign dev_not_ready_o = !ok_o;
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for cfg_loader, attached through bind.
module cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       img_ready_o,
    input logic       cfg_prog_n_o,
    input logic       cfg_cclk_o,
    input logic [7:0] cfg_data_o,
    input logic       cfg_init_i,
    input logic       cfg_done_i,
    input logic       busy_o,
    input logic       ok_o,
    input logic       err_o,
    input logic [1:0] err_cause_o,
    input logic       dev_not_ready_o
);
    assert_prog_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n_o |-> busy_o);

    assert_cclk_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk_o) |-> $past(cfg_init_i));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cclk_o |-> $stable(cfg_data_o));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cfg_prog_n_o && !cfg_cclk_o && !img_ready_o));

    assert_ok_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(cfg_done_i));

    assert_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_o) && err_cause_o == 2'b11) |-> !$past(cfg_done_i));

    assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o) && (dev_not_ready_o == !ok_o) && !(busy_o && ok_o));

    assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> (busy_o && cfg_init_i && cfg_prog_n_o));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .img_ready_o     (img_ready_o),
    .cfg_prog_n_o    (cfg_prog_n_o),
    .cfg_cclk_o      (cfg_cclk_o),
    .cfg_data_o      (cfg_data_o),
    .cfg_init_i      (cfg_init_i),
    .cfg_done_i      (cfg_done_i),
    .busy_o          (busy_o),
    .ok_o            (ok_o),
    .err_o           (err_o),
    .err_cause_o     (err_cause_o),
    .dev_not_ready_o (dev_not_ready_o)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
    localparam int PL  = 5;
    localparam int DIV = 4;
    localparam int TO  = 40;
    localparam int TB  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       start = 1'b0, valid = 1'b0, last = 1'b0;
    logic [7:0] data = '0;
    logic       ready, prog_n, cclk, busy, ok, err, not_ready;
    logic [7:0] cdata;
    logic [1:0] cause;
    logic       init = 1'b0;
    logic       done_val = 1'b0;

    cfg_loader #(
        .PROG_LOW_CYCLES (PL),
        .CCLK_DIV        (DIV),
        .INIT_WAIT_MAX   (TO),
        .TAIL_CCLKS      (TB)
    ) u_cfg_loader (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .img_valid_i (valid), .img_data_i (data), .img_last_i (last),
        .img_ready_o (ready), .cfg_prog_n_o (prog_n), .cfg_cclk_o (cclk),
        .cfg_data_o (cdata), .cfg_init_i (init), .cfg_done_i (done_val),
        .busy_o (busy), .ok_o (ok), .err_o (err), .err_cause_o (cause),
        .dev_not_ready_o (not_ready)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Device model controls
    bit init_en = 1'b0, kill_init = 1'b0;
    int init_delay = 0, icnt = 0;

    always @(posedge clk) begin
        if (!rst_n || !prog_n) begin
            icnt <= 0; init <= 1'b0;
        end else if (kill_init) begin
            init <= 1'b0;
        end else if (init_en) begin
            if (icnt >= init_delay) init <= 1'b1;
            else icnt <= icnt + 1;
        end
    end

    // Capture monitors
    logic [7:0] cap [0:63];
    logic [7:0] exp_b [0:63];
    int rise_cnt = 0, spacing_bad = 0, early_rise = 0, prog_falls = 0, ready_seen = 0;
    bit spacing_on = 1'b0;
    longint last_t = 0;

    always @(posedge cclk) begin
        if (rise_cnt < 64) cap[rise_cnt] = cdata;
        if (spacing_on && rise_cnt > 0 && ($time - last_t) != DIV * 10) spacing_bad++;
        last_t = $time;
        rise_cnt++;
        if (!init && !kill_init) early_rise++;
    end
    always @(negedge prog_n) prog_falls++;
    always @(negedge clk) if (ready === 1'b1) ready_seen++;

    task automatic chk(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pick_byte(int i);
        return 8'($urandom() ^ (i * 37));
    endfunction

    function automatic int exp_rises(int n);
        return n + TB;
    endfunction

    task automatic clear_mon();
        rise_cnt = 0; spacing_bad = 0; early_rise = 0; prog_falls = 0; ready_seen = 0;
    endtask

    task automatic pulse_start_and_measure();
        int w;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        w = 0;
        while (!prog_n && w < 1000) begin w++; @(negedge clk); end
        chk("R2", "strobe low width", w, PL);
    endtask

    task automatic run_case(int n, bit gaps, int delay, bit done_v, bit restart_mid,
                            int kill_at, int pause_at, bit spacing);
        int t;
        clear_mon();
        kill_init = 1'b0; init_en = 1'b1; init_delay = delay;
        done_val = done_v; spacing_on = spacing;
        pulse_start_and_measure();
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                valid = 1'b0;
                repeat (8) @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    chk("R5", "clock parked low while no byte", int'(cclk), 0);
                    @(negedge clk);
                end
            end
            if (gaps && $urandom_range(0, 2) == 0) begin
                valid = 1'b0;
                repeat ($urandom_range(1, 3)) @(negedge clk);
            end
            exp_b[i] = pick_byte(i);
            valid = 1'b1; data = exp_b[i]; last = (i == n - 1);
            if (i == kill_at) kill_init = 1'b1;
            if (restart_mid && i == n / 2) start = 1'b1;
            #1;
            t = 0;
            while (!ready && busy && t < 500) begin
                @(negedge clk); start = 1'b0; #1; t++;
            end
            if (!busy) break;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        valid = 1'b0; last = 1'b0; start = 1'b0;
        t = 0;
        while (busy && t < 2000) begin @(negedge clk); t++; end
    endtask

    function automatic int mismatches(int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (cap[i] !== exp_b[i]) m++;
        return m;
    endfunction

    task automatic check_ok(string tag, int n);
        chk("R7", {tag, " success"}, int'(ok), 1);
        chk("R10", {tag, " error low"}, int'(err), 0);
        chk("R10", {tag, " not-ready released"}, int'(not_ready), 0);
        chk("R7", {tag, " tail clocks"}, rise_cnt, exp_rises(n));
        chk("R4", {tag, " byte mismatches"}, mismatches(n), 0);
        chk("R3", {tag, " early clock edges"}, early_rise, 0);
        chk("R11", {tag, " ready low when finished"}, int'(ready), 0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int k, r0, n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "strobe high", int'(prog_n), 1);
        chk("R1", "clock low", int'(cclk), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ok/err", int'(ok) + int'(err), 0);
        chk("R1", "not-ready", int'(not_ready), 1);
        chk("R1", "ready", int'(ready), 0);
        chk("R1", "cause", int'(cause), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", int'(busy) + int'(ok) + int'(err), 0);

        // Continuous stream, clock spacing
        run_case(12, 1'b0, 7, 1'b1, 1'b0, -1, -1, 1'b1);
        check_ok("cont", 12);
        chk("R5", "clock period spacing errors", spacing_bad, 0);
        chk("R2", "single strobe fall", prog_falls, 1);

        // Gaps, pause, start while busy
        run_case(10, 1'b1, 3, 1'b1, 1'b1, -1, 4, 1'b0);
        check_ok("gaps", 10);
        chk("R2", "start while busy ignored", prog_falls, 1);

        // Init timeout
        clear_mon();
        init_en = 1'b0; kill_init = 1'b0;
        pulse_start_and_measure();
        k = 0;
        while (!err && k < 1000) begin @(negedge clk); k++; end
        chk("R6", "timeout cycles", k, TO);
        chk("R6", "cause init timeout", int'(cause), 1);
        chk("R6", "strobe high in error", int'(prog_n), 1);
        chk("R3", "no clock without init", rise_cnt, 0);
        chk("R11", "no ready without init", ready_seen, 0);
        chk("R10", "not-ready in error", int'(not_ready), 1);

        // Restart after error, random cases
        for (int c = 0; c < 3; c++) begin
            n = $urandom_range(1, 24);
            run_case(n, 1'($urandom_range(0, 1)), $urandom_range(0, 20), 1'b1, 1'b0, -1, -1, 1'b0);
            check_ok("random", n);
            chk("R10", "restart repeats strobe", prog_falls, 1);
        end

        // Done missing
        run_case(6, 1'b0, 2, 1'b0, 1'b0, -1, -1, 1'b0);
        chk("R8", "error on missing done", int'(err), 1);
        chk("R8", "cause done missing", int'(cause), 3);
        chk("R8", "tail clocks before sample", rise_cnt, exp_rises(6));
        chk("R10", "no success", int'(ok), 0);

        // Init lost mid-stream
        run_case(20, 1'b0, 2, 1'b1, 1'b0, 5, -1, 1'b0);
        chk("R9", "error on init loss", int'(err), 1);
        chk("R9", "cause init lost", int'(cause), 2);
        chk("R9", "clock low", int'(cclk), 0);
        r0 = rise_cnt;
        repeat (10) @(negedge clk);
        chk("R9", "clock stopped", rise_cnt, r0);
        kill_init = 1'b0;

        // Single byte, init immediately
        run_case(1, 1'b0, 0, 1'b1, 1'b0, -1, -1, 1'b1);
        check_ok("single", 1);
        chk("R5", "single byte spacing", spacing_bad, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule